// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits between a flash array's read path and the host bus. While an embedded byte program or an erase is running, suspended or has run out of time, it replaces the byte the host reads with a status byte. The status bits show completion through a data-polling bit, progress through toggle bits, and a sticky time-limit error. At all other times the array byte passes through unchanged. It also drives a registered ready/busy flag.

Reads arrive as a valid/ready request stream that carries the sector field of the read address and the array byte for that address. Each accepted request produces exactly one response beat on a valid/ready response stream that holds one entry. A request is accepted only when the response slot is empty or is being drained in the same cycle, so `req_ready` equals `!rsp_valid || rsp_ready`. A response held by back-pressure keeps its data stable. A request that is not accepted does not advance any toggle bit. The operation controls (kind, busy, suspended, time-limit, start, clear) are plain level or pulse inputs.

Top module: `embop_status_unit`

## Requirements
- R1: When no operation is busy or suspended and no time-limit error is latched, the response byte equals the array byte of the request.
- R2: While a byte program is busy (kind code 0), bit 7 of the response is the inverse of bit 7 of the byte being programmed. Every address returns status.
- R3: While a chip erase (kind 1) or sector erase (kind 2) is busy and not suspended, bit 7 reads 0 and every address returns status.
- R4: While busy, bit 6 of each accepted read takes the current toggle value and then inverts it. The read address has no effect on this. The first read after a start returns 0.
- R5: A one-cycle time-limit pulse sets bit 5. The bit stays set, and status is returned, until the clear-command input is pulsed. While latched and not busy, bit 7 of a program status shows the true programmed bit.
- R6: During erase suspend with no program running, reads in the erase sector return status with bit 7 = 1, and bit 6 frozen. Reads in other sectors return array data.
- R7: Bit 2 reports a second toggle. It inverts on each accepted read whose sector field matches the erase sector, during both active and suspended erase. For chip erase every sector matches. Reads outside the sector report it without change.
- R8: During a program run inside erase suspend (busy and suspended, kind 0), every address returns program status. Bit 6 toggles, and bit 2 toggles on reads in the suspended sector.
- R9: The ready flag is 1 after reset. One cycle after busy is seen it reads 0, and one cycle after busy falls it reads 1. It stays 1 while suspended and not busy.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. A stalled response keeps its valid and its data. Requests that are not accepted leave the toggle bits unchanged.
- R11: In a status byte, bits 4, 3, 1 and 0 and all bits above 7 read 0.
- R12: A start pulse clears both toggle bits. The pulse takes priority over a read accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 2 | 0 program, 1 chip erase, 2 sector erase |
| op_busy | input | 1 | Embedded algorithm running |
| op_suspended | input | 1 | Sector erase suspended |
| op_timeout | input | 1 | Time-limit exceeded pulse |
| op_start | input | 1 | New operation starts, clears toggles |
| clr_cmd | input | 1 | Reset command, clears time-limit bit |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| erase_sector | input | SECT_W | Sector under erase |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted |
| req_sector | input | SECT_W | Sector field of the read address |
| req_array | input | DATA_W | Array byte at the read address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W | Read byte, status or array |
| ready_o | output | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with SECT_W = 2 and DATA_W = 8. Four sectors are then enough to place reads inside and outside the erase sector, on both sides of it, and across all four sector codes during chip erase. With the 8-bit byte, every status bit sits in a position the checks can test one by one, including the bits that must read 0. Toggle sequences stay short enough to follow read by read through program, erase, suspend, program-in-suspend and resume.

// File: rtl/embop_pkg.sv
package embop_pkg;
  typedef enum logic [1:0] {
    OPK_PROG = 2'd0,
    OPK_CHIP = 2'd1,
    OPK_SECT = 2'd2
  } op_kind_e;

  localparam int POLL_BIT = 7;
  localparam int TGL_BIT  = 6;
  localparam int TMO_BIT  = 5;
  localparam int ETGL_BIT = 2;
endpackage

// File: rtl/embop_sector_match.sv
module embop_sector_match #(
  parameter int SECT_W = 4
) (
  input  logic [1:0]        op_kind,
  input  logic [SECT_W-1:0] erase_sector,
  input  logic [SECT_W-1:0] rd_sector,
  output logic              in_sect
);
  import embop_pkg::*;
  logic same;
  assign same    = (rd_sector == erase_sector);
  assign in_sect = (op_kind == OPK_CHIP) ? 1'b1 : same;
endmodule

// File: rtl/embop_toggle_regs.sv
module embop_toggle_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic adv,
  input  logic t6_en,
  input  logic t2_en,
  output logic tgl6,
  output logic tgl2
);
  always_ff @(posedge clk) begin
    if (!rst_n || op_start) begin
      tgl6 <= 1'b0;
      tgl2 <= 1'b0;
    end else if (adv) begin
      if (t6_en) tgl6 <= ~tgl6;
      if (t2_en) tgl2 <= ~tgl2;
    end
  end

  AST_TGL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (!tgl6 && !tgl2)); // R12
  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !op_start) |=> ($stable(tgl6) && $stable(tgl2))); // R10
endmodule

// File: rtl/embop_status_compose.sv
module embop_status_compose #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        op_kind,
  input  logic              op_busy,
  input  logic              op_suspended,
  input  logic              tmo,
  input  logic              prog_msb,
  input  logic              in_sect,
  input  logic              tgl6,
  input  logic              tgl2,
  input  logic [DATA_W-1:0] arr,
  output logic [DATA_W-1:0] out,
  output logic              t6_en,
  output logic              t2_en
);
  import embop_pkg::*;
  logic              stat_sel;
  logic              poll;
  logic [DATA_W-1:0] stat;

  assign stat_sel = (op_busy && !op_suspended) || tmo ||
                    (op_suspended && (op_busy || in_sect));

  always_comb begin
    if (op_kind == OPK_PROG) poll = op_busy ? ~prog_msb : prog_msb;
    else                     poll = !(op_busy && !op_suspended);
  end

  assign t6_en = op_busy;
  assign t2_en = (op_busy || op_suspended) && in_sect &&
                 ((op_kind != OPK_PROG) || op_suspended);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT)      begin : g_p assign stat[i] = poll; end
    else if (i == TGL_BIT)  begin : g_t assign stat[i] = tgl6; end
    else if (i == TMO_BIT)  begin : g_m assign stat[i] = tmo;  end
    else if (i == ETGL_BIT) begin : g_e assign stat[i] = tgl2; end
    else                    begin : g_z assign stat[i] = 1'b0; end
  end

  assign out = stat_sel ? stat : arr;
endmodule

// File: rtl/embop_rsp_slice.sv
module embop_rsp_slice #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= in_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
endmodule

// File: rtl/embop_status_unit.sv
module embop_status_unit #(
  parameter int SECT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_kind,
  input  logic              op_busy,
  input  logic              op_suspended,
  input  logic              op_timeout,
  input  logic              op_start,
  input  logic              clr_cmd,
  input  logic              prog_msb,
  input  logic [SECT_W-1:0] erase_sector,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SECT_W-1:0] req_sector,
  input  logic [DATA_W-1:0] req_array,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ready_o
);
  logic              in_sect, tgl6, tgl2, t6_en, t2_en, tmo_q, accept;
  logic [DATA_W-1:0] composed;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q   <= 1'b0;
      ready_o <= 1'b1;
    end else begin
      ready_o <= !op_busy;
      if (clr_cmd)         tmo_q <= 1'b0;
      else if (op_timeout) tmo_q <= 1'b1;
    end
  end

  embop_sector_match #(.SECT_W(SECT_W)) u_match (
    .op_kind(op_kind), .erase_sector(erase_sector),
    .rd_sector(req_sector), .in_sect(in_sect));

  embop_toggle_regs u_tgl (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .adv(accept),
    .t6_en(t6_en), .t2_en(t2_en), .tgl6(tgl6), .tgl2(tgl2));

  embop_status_compose #(.DATA_W(DATA_W)) u_comp (
    .op_kind(op_kind), .op_busy(op_busy), .op_suspended(op_suspended),
    .tmo(tmo_q), .prog_msb(prog_msb), .in_sect(in_sect), .tgl6(tgl6),
    .tgl2(tgl2), .arr(req_array), .out(composed), .t6_en(t6_en),
    .t2_en(t2_en));

  embop_rsp_slice #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .in_data(composed), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data));

  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |=> !ready_o); // R9
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !clr_cmd) |=> tmo_q); // R5
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op_busy && !op_suspended && !tmo_q) |=>
      (rsp_data == $past(req_array))); // R1
endmodule

// File: tb/embop_status_unit_tb_top.sv
module embop_status_unit_tb_top;
  localparam int SW = 2;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic [1:0] op_kind = 0;
  logic op_busy = 0, op_suspended = 0, op_timeout = 0, op_start = 0, clr_cmd = 0;
  logic prog_msb = 0;
  logic [SW-1:0] erase_sector = 0, req_sector = 0;
  logic [DW-1:0] req_array = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic req_ready, rsp_valid, ready_o;
  logic [DW-1:0] rsp_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  embop_status_unit #(.SECT_W(SW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_busy(op_busy),
    .op_suspended(op_suspended), .op_timeout(op_timeout), .op_start(op_start),
    .clr_cmd(clr_cmd), .prog_msb(prog_msb), .erase_sector(erase_sector),
    .req_valid(req_valid), .req_ready(req_ready), .req_sector(req_sector),
    .req_array(req_array), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .ready_o(ready_o));

  typedef struct packed {
    logic       start;
    logic [1:0] kind;
    logic       busy;
    logic       susp;
    logic [1:0] esec;
    logic [1:0] sec;
    logic [7:0] arr;
    logic       pmsb;
    logic [7:0] exp;
  } vec_t;

  // Kind codes: 0 program, 1 chip erase, 2 sector erase
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 2'd0, 8'h3C, 1'b1, 8'h00}, // R2 R4
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2'd3, 8'h3C, 1'b1, 8'h40}, // R4
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2'd0, 8'h3C, 1'b0, 8'h80}, // R2
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h25, 1'b0, 8'h25}, // R1
    '{1'b1, 2'd2, 1'b1, 1'b0, 2'd1, 2'd1, 8'hFF, 1'b0, 8'h00}, // R3 R11 R12
    '{1'b0, 2'd2, 1'b1, 1'b0, 2'd1, 2'd2, 8'hFF, 1'b0, 8'h44}, // R7
    '{1'b0, 2'd2, 1'b1, 1'b0, 2'd1, 2'd1, 8'hFF, 1'b0, 8'h04}, // R7
    '{1'b0, 2'd2, 1'b0, 1'b1, 2'd1, 2'd1, 8'h11, 1'b0, 8'hC0}, // R6
    '{1'b0, 2'd2, 1'b0, 1'b1, 2'd1, 2'd0, 8'h5A, 1'b0, 8'h5A}, // R6
    '{1'b0, 2'd2, 1'b0, 1'b1, 2'd1, 2'd1, 8'h11, 1'b0, 8'hC4}, // R6 R7
    '{1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 2'd0, 8'h11, 1'b1, 8'h40}, // R8
    '{1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 2'd1, 8'h11, 1'b1, 8'h00}, // R8
    '{1'b0, 2'd2, 1'b0, 1'b1, 2'd1, 2'd1, 8'h11, 1'b0, 8'hC4}, // R6
    '{1'b0, 2'd2, 1'b1, 1'b0, 2'd1, 2'd0, 8'h11, 1'b0, 8'h40}, // R3
    '{1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 2'd3, 8'h99, 1'b0, 8'h00}, // R7 chip
    '{1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 2'd0, 8'h99, 1'b0, 8'h44}, // R7 chip
    '{1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 8'hFF, 1'b0, 8'hFF}  // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] sec, input logic [7:0] arr);
    req_sector = sec; req_array = arr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pulse_start();
    op_start = 1;
    @(negedge clk);
    op_start = 0;
  endtask

  initial begin
    #1500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset ready", ready_o, 1);
    check("R10 reset rsp_valid", rsp_valid, 0);
    check("R10 reset req_ready", req_ready, 1);

    for (int i = 0; i < NV; i++) begin
      op_kind = VEC[i].kind; op_busy = VEC[i].busy; op_suspended = VEC[i].susp;
      erase_sector = VEC[i].esec; prog_msb = VEC[i].pmsb;
      if (VEC[i].start) pulse_start();
      do_read(VEC[i].sec, VEC[i].arr);
      check($sformatf("vector %0d R1-group", i), rsp_data, VEC[i].exp);
      check("R10 rsp_valid after accept", rsp_valid, 1);
    end

    // R9: ready flag follows busy with one cycle delay
    op_busy = 0; op_suspended = 0;
    @(negedge clk);
    op_busy = 1;
    check("R9 same cycle", ready_o, 1);
    @(negedge clk);
    check("R9 busy seen", ready_o, 0);
    op_busy = 0; op_suspended = 1;
    @(negedge clk);
    check("R9 suspended ready", ready_o, 1);
    op_suspended = 0;

    // R5: sticky time-limit bit
    op_kind = 2'd0; op_busy = 1; prog_msb = 0;
    pulse_start();
    op_timeout = 1;
    @(negedge clk);
    op_timeout = 0; op_busy = 0;
    @(negedge clk);
    do_read(2'd0, 8'h77);
    check("R5 latched", rsp_data, 8'h20);
    do_read(2'd3, 8'h77);
    check("R5 still latched", rsp_data, 8'h20);
    clr_cmd = 1;
    @(negedge clk);
    clr_cmd = 0;
    do_read(2'd3, 8'h77);
    check("R5 cleared", rsp_data, 8'h77);

    // R10: back-pressure
    op_kind = 2'd0; op_busy = 1; prog_msb = 0;
    pulse_start();
    rsp_ready = 0; req_sector = 0; req_array = 8'h00; req_valid = 1;
    @(negedge clk);
    check("R10 first beat", rsp_data, 8'h80);
    check("R10 stall ready", req_ready, 0);
    @(negedge clk);
    check("R10 held valid", rsp_valid, 1);
    check("R10 held data", rsp_data, 8'h80);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R10 R4 second beat", rsp_data, 8'hC0);
    @(negedge clk);
    check("R10 drained", rsp_valid, 0);

    // R12: start wins over same-cycle read
    op_start = 1;
    do_read(2'd0, 8'h00);
    op_start = 0;
    do_read(2'd0, 8'h00);
    check("R12 start priority", rsp_data, 8'h80);
    op_busy = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule